// File: doc/BRIEF.md
# Burst Address Order Sequencer

This block produces the word addresses of a memory burst, one per completed data phase. A master loads a starting word address together with an ordering code, a cache line size code and a wide-transfer flag. The block then presents the first address and steps to the next one each time the master reports that a data phase has finished. Three orderings are available:

- **Linear**: plain increment.
- **Toggle**: the starting address XORed with a rising word count, a critical-word-first order.
- **Wrap**: wraps inside each cache line and then moves to the same offset in the next line, also critical-word-first.

Alongside each address the block raises a flag meaning "terminate after this word". The flag is set when the burst has to stop at the end of a line. It is also set when the requested combination cannot be honoured, in which case the burst shrinks to a single word. Bus signalling is outside the block.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `addr` and `last` are all zero.
- R2: A cycle with `start` high makes `busy` 1 and `addr` equal to `start_addr` after the next clock edge. `start` wins over `advance` and restarts a burst already in progress.
- R3: With `busy` high and `last` low, a cycle with `advance` high moves `addr` and `last` to the next word of the burst. A cycle with both `advance` and `start` low leaves `busy`, `addr` and `last` unchanged.
- R4: Order code 0 (linear) gives word n at `start_addr + n*s`, where s is 1, or 2 when `wide` is set. It never wraps at a line. `last` is raised when the next step would pass the top of the address space.
- R5: Order code 1 (toggle) gives word n at `start_addr XOR (n*s)`. `last` is raised when n*s equals L - s, where L is the line size in words, so the burst stays inside one line.
- R6: Order code 2 (wrap) gives word n at line `start_addr/L + (n*s)/L`, offset `(start_addr mod L + n*s) mod L`. `last` is raised only on the final word of the topmost line of the address space.
- R7: When `start_addr mod L` is 0, all three orders give `start_addr + n*s` for every word within the first line.
- R8: Order code 3 is unsupported: `last` is 1 on the first word.
- R9: `line_cfg` 0, 1 and 2 select L = 4, 8 and 16 words. `line_cfg` 3 is unsupported and gives a single-word burst in every order.
- R10: With `wide` set, the address moves by 2 words per data phase. An odd `start_addr` (byte address bit 2 set) gives a single-word burst.
- R11: `advance` while `last` is 1 ends the burst: after the next edge `busy` and `last` are 0 and `addr` keeps its value. `advance` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new burst |
| start_addr | input | AW | Starting word address |
| order | input | 2 | 0 linear, 1 toggle, 2 wrap, 3 unsupported |
| line_cfg | input | 2 | Line size code: 0=4, 1=8, 2=16 words, 3 unsupported |
| wide | input | 1 | Two words per data phase |
| advance | input | 1 | Current data phase completed |
| busy | output | 1 | A burst is active |
| addr | output | AW | Current word address |
| last | output | 1 | Terminate after this word |

## Verification
A corrupted word counter or a stale latched configuration shows up on `addr` at the very next `advance`. It shows as a wrong offset within the line, or as a jump to the wrong line on a wrap. A bad line-size decode instead moves the cycle in which `last` rises, or fails to shrink an illegal request to one word. The bench therefore compares `addr` and `last` against a model after every step. It also checks both near the top of the address space and with idle gaps between steps, so that any divergence is caught within one data phase.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int LG_W = 3;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'd0,
    ORD_TOGGLE = 2'd1,
    ORD_WRAP   = 2'd2,
    ORD_RSVD   = 2'd3
  } order_t;

  // log2 of the line size in words for a config code
  function automatic logic [LG_W-1:0] line_lg(input logic [1:0] code);
    case (code)
      2'd0:    line_lg = LG_W'(2);
      2'd1:    line_lg = LG_W'(3);
      2'd2:    line_lg = LG_W'(4);
      default: line_lg = LG_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/bsq_cfg_decode.sv
module bsq_cfg_decode
  import bsq_pkg::*;
(
  input  logic [1:0]      order_code,
  input  logic [1:0]      line_code,
  input  logic            wide,
  input  logic            start_lsb,
  output order_t          order,
  output logic [LG_W-1:0] lg,
  output logic            single
);
  always_comb begin
    order  = order_t'(order_code);
    lg     = line_lg(line_code);
    // any request that cannot be honoured shrinks to one word
    single = (order == ORD_RSVD) || (line_code == 2'd3) || (wide && start_lsb);
  end
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import bsq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]   base,
  input  order_t          order,
  input  logic [LG_W-1:0] lg,
  input  logic            wide,
  input  logic            single,
  input  logic [AW-1:0]   cnt,
  output logic [AW-1:0]   addr,
  output logic            last
);
  localparam logic [AW-1:0] TOP = '1;

  logic [AW-1:0] mask;
  logic [AW-1:0] step;
  logic [AW-1:0] lane_end;

  always_comb begin
    mask     = (AW'(1) << lg) - AW'(1);
    step     = wide ? AW'(2) : AW'(1);
    lane_end = mask + AW'(1) - step;
    addr     = base;
    last     = 1'b1;
    case (order)
      ORD_LINEAR: begin
        addr = base + cnt;
        last = wide ? (addr >= TOP - AW'(1)) : (addr == TOP);
      end
      ORD_TOGGLE: begin
        addr = base ^ cnt;
        last = (cnt == lane_end);
      end
      ORD_WRAP: begin
        addr = ((base & ~mask) + (cnt & ~mask)) | ((base + cnt) & mask);
        last = ((cnt & mask) == lane_end) && ((addr | mask) == TOP);
      end
      default: begin
        addr = base;
        last = 1'b1;
      end
    endcase
    if (single) last = 1'b1;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bsq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    order,
  input  logic [1:0]    line_cfg,
  input  logic          wide,
  input  logic          advance,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          last
);
  order_t          order_d, order_q, g_order;
  logic [LG_W-1:0] lg_d, lg_q, g_lg;
  logic            single_d, single_q, g_single;
  logic [AW-1:0]   base_q, cnt_q, cnt_nx, g_base, g_cnt, g_addr;
  logic            wide_q, g_wide, g_last;
  logic            busy_q, last_q;
  logic [AW-1:0]   addr_q;

  bsq_cfg_decode u_dec (
    .order_code (order),
    .line_code  (line_cfg),
    .wide       (wide),
    .start_lsb  (start_addr[0]),
    .order      (order_d),
    .lg         (lg_d),
    .single     (single_d)
  );

  assign cnt_nx = cnt_q + (wide_q ? AW'(2) : AW'(1));

  // one generator serves both the first word and every later step
  always_comb begin
    if (start) begin
      g_base = start_addr; g_order = order_d; g_lg = lg_d;
      g_wide = wide;       g_single = single_d; g_cnt = '0;
    end else begin
      g_base = base_q;     g_order = order_q;  g_lg = lg_q;
      g_wide = wide_q;     g_single = single_q; g_cnt = cnt_nx;
    end
  end

  bsq_addr_gen #(.AW(AW)) u_gen (
    .base   (g_base),
    .order  (g_order),
    .lg     (g_lg),
    .wide   (g_wide),
    .single (g_single),
    .cnt    (g_cnt),
    .addr   (g_addr),
    .last   (g_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      last_q   <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      base_q   <= '0;
      order_q  <= ORD_LINEAR;
      lg_q     <= '0;
      wide_q   <= 1'b0;
      single_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      base_q   <= start_addr;
      order_q  <= order_d;
      lg_q     <= lg_d;
      wide_q   <= wide;
      single_q <= single_d;
      cnt_q    <= '0;
      addr_q   <= g_addr;
      last_q   <= g_last;
    end else if (busy_q && advance) begin
      if (last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_nx;
        addr_q <= g_addr;
        last_q <= g_last;
      end
    end
  end

  assign busy = busy_q;
  assign addr = addr_q;
  assign last = last_q;

  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && (addr == $past(start_addr)));

  a_r3_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
    (!start && !advance) |=> $stable(addr) && $stable(last) && $stable(busy));

  a_r8_unsupported_order: assert property (@(posedge clk) disable iff (rst)
    (start && order == 2'd3) |=> last);

  a_r10_wide_even: assert property (@(posedge clk) disable iff (rst)
    (busy && wide_q && !single_q) |-> !addr[0]);

  a_r11_end_on_last: assert property (@(posedge clk) disable iff (rst)
    (busy && last && advance && !start) |=> !busy && !last);

  a_r11_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy && $stable(addr));
endmodule

// File: tb/burst_seq_bench.sv
`timescale 1ns/1ps
module burst_seq_bench;
  localparam int AW = 16;
  localparam int SPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    order = '0;
  logic [1:0]    line_cfg = '0;
  logic          wide = 1'b0;
  logic          advance = 1'b0;
  logic          busy, last;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_seq #(.AW(AW)) u_burst_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .order(order), .line_cfg(line_cfg), .wide(wide), .advance(advance),
    .busy(busy), .addr(addr), .last(last)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit is_single(int sa, int ord, int lc, int w);
    return (ord == 3) || (lc == 3) || (w != 0 && (sa % 2) == 1);
  endfunction

  function automatic int m_addr(int sa, int ord, int lc, int w, int n);
    int s = (w != 0) ? 2 : 1;
    int k = n * s;
    int lw = 4 << lc;
    case (ord)
      0: return (sa + k) % SPACE;
      1: return sa ^ k;
      2: return ((sa / lw + k / lw) * lw + ((sa % lw + k % lw) % lw)) % SPACE;
      default: return sa;
    endcase
  endfunction

  function automatic bit m_last(int sa, int ord, int lc, int w, int n);
    int s = (w != 0) ? 2 : 1;
    int k = n * s;
    int lw = 4 << lc;
    int a = m_addr(sa, ord, lc, w, n);
    if (is_single(sa, ord, lc, w)) return 1'b1;
    case (ord)
      0: return (a + s) >= SPACE;
      1: return k == lw - s;
      2: return (k % lw == lw - s) && (a / lw == SPACE / lw - 1);
      default: return 1'b1;
    endcase
  endfunction

  // runs one burst of up to maxw words; leaves it open if the cap is hit
  task automatic run_burst(int sa, int ord, int lc, int w, int maxw, bit gaps);
    int s = (w != 0) ? 2 : 1;
    int lw = 4 << lc;
    @(negedge clk);
    start = 1'b1; start_addr = AW'(sa); order = 2'(ord); line_cfg = 2'(lc);
    wide = w[0]; advance = $urandom_range(0, 1) == 1; // R2: start wins
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    start_addr = AW'($urandom); order = 2'($urandom); wide = $urandom_range(0, 1) == 1;
    chk("R2 busy", busy, 1);
    for (int n = 0; n < maxw; n++) begin
      chk("R4/R5/R6/R8/R9/R10 addr", addr, m_addr(sa, ord, lc, w, n));
      chk("R4/R5/R6/R8/R9/R10 last", last, m_last(sa, ord, lc, w, n));
      if (lc != 3 && ord != 3 && !is_single(sa, ord, lc, w) && sa % lw == 0 && n * s < lw)
        chk("R7 zero offset", addr, (sa + n * s) % SPACE);
      if (gaps && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk("R3 hold addr", addr, m_addr(sa, ord, lc, w, n));
        chk("R3 hold last", last, m_last(sa, ord, lc, w, n));
      end
      if (m_last(sa, ord, lc, w, n)) begin
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        chk("R11 busy drops", busy, 0);
        chk("R11 last drops", last, 0);
        chk("R11 addr kept", addr, m_addr(sa, ord, lc, w, n));
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        chk("R11 idle advance busy", busy, 0);
        chk("R11 idle advance addr", addr, m_addr(sa, ord, lc, w, n));
        return;
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 addr", addr, 0);
    chk("R1 last", last, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after", busy, 0);
    chk("R1 last after", last, 0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk("R11 idle advance at start", busy, 0);

    // directed corners
    run_burst('h1236, 1, 1, 0, 20, 1'b0);  // R5 toggle mid line
    run_burst('h1236, 2, 0, 0, 12, 1'b0);  // R6 wrap
    run_burst('h2040, 0, 2, 0, 20, 1'b0);  // R7 linear aligned
    run_burst('h2040, 1, 2, 0, 20, 1'b0);  // R7 toggle aligned
    run_burst('h2040, 2, 2, 0, 20, 1'b0);  // R7 wrap aligned
    run_burst('hFFFD, 0, 0, 0, 10, 1'b0);  // R4 top of space
    run_burst('hFFF6, 2, 0, 0, 20, 1'b0);  // R6 wrap into top line
    run_burst('h0100, 3, 0, 0, 5, 1'b0);   // R8
    run_burst('h0105, 0, 3, 0, 5, 1'b0);   // R9 unsupported line
    run_burst('h0105, 2, 3, 0, 5, 1'b0);   // R9
    run_burst('h0106, 1, 1, 1, 10, 1'b0);  // R10 wide toggle
    run_burst('hFFF8, 0, 0, 1, 10, 1'b0);  // R10 wide linear to top
    run_burst('h0107, 0, 0, 1, 5, 1'b0);   // R10 odd start single
    run_burst('h3333, 0, 1, 0, 4, 1'b0);   // left open, restarted next (R2)

    for (int i = 0; i < 300; i++) begin
      int sa = $urandom_range(0, SPACE - 1);
      int ord = $urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2);
      int lc = $urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2);
      int w = $urandom_range(0, 2) == 0 ? 1 : 0;
      if (w != 0 && $urandom_range(0, 3) != 0) sa = sa & ~1;
      if ($urandom_range(0, 7) == 0) sa = SPACE - 1 - $urandom_range(0, 40);
      run_burst(sa, ord, lc, w, $urandom_range(1, 40), 1'b1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule